// File: doc/BRIEF.md
# Parallel Bit Extract Unit

This execution unit gathers the bits of a data operand at the positions a mask operand marks with ones, and packs them side by side at the low end of a result word. Unlike a shift or a fixed field extract, the chosen positions may be scattered anywhere in the word. The chosen bits arrive contiguously from bit 0 upward, in the same relative order they had in the data operand.

A decode stage presents the data, the mask, an operand-size select (full width or narrow width), a valid strobe and an indication that the encoding is illegal. The unit returns the packed result one cycle later with a result-valid strobe. It raises an undefined-instruction fault strobe instead when the encoding was illegal. The unit accepts a new operation on every cycle. The datapath ranks each mask bit by counting the set mask bits below it, then lets every result bit pick the data bit whose rank matches its own index. No condition flags are produced.

Top module: `pbx_unit`

## Requirements
- R1: For each mask position holding a 1, scanned from bit 0 upward, the data bit at that position goes to the next free result bit, starting at result bit 0. Example: with mask bits 2, 5, 7 and 28 set, result bits 0..3 hold data bits 2, 5, 7 and 28.
- R2: Every result bit at or above the number of set mask bits (within the selected width) is zero.
- R3: With `in_wide` = 0 (narrow, 32-bit), only bits 31:0 of data and mask take part, and result bits 63:32 are zero. With `in_wide` = 1 all 64 bits take part.
- R4: An all-zero mask yields an all-zero result in either width.
- R5: An all-ones mask returns the data operand unchanged within the selected width.
- R6: An operation is accepted when `in_valid` = 1 and `in_bad_enc` = 0. `out_valid` is 1 exactly in the cycle after each accepted operation and 0 after any cycle with `in_valid` = 0. Back-to-back operations are accepted on consecutive cycles.
- R7: When `in_valid` = 1 and `in_bad_enc` = 1, the next cycle shows `out_fault` = 1 and `out_valid` = 0, and `out_result` keeps its previous value. `out_valid` and `out_fault` are never both 1.
- R8: A synchronous active-high reset clears `out_valid`, `out_fault` and `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_wide | input | 1 | 1 = full 64-bit operands, 0 = narrow 32-bit operands |
| in_bad_enc | input | 1 | Encoding is illegal; raise a fault instead of computing |
| in_data | input | W (64) | Data operand the bits are taken from |
| in_mask | input | W (64) | Mask operand selecting the bit positions |
| out_valid | output | 1 | Result valid, one cycle after an accepted operation |
| out_result | output | W (64) | Packed result |
| out_fault | output | 1 | Undefined-instruction fault strobe |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath, a 32-bit narrow width and the rippling rank counter. This brings both operand sizes within reach at one instance, so the zeroing of the upper half in narrow mode is observed on a real port and not on a width that simply does not exist. Random data and masks in both widths are streamed on consecutive cycles and compared against a bit-serial model. Directed cases cover the worked example, the empty and full masks, narrow operands carrying junk in their upper halves, and a faulting operation placed between good ones.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
   // Selects how each mask bit's rank (number of set mask bits below it) is formed.
   typedef enum logic [0:0] {
      PBX_RANK_RIPPLE    = 1'b0,  // one running adder chain across the word
      PBX_RANK_LOOKAHEAD = 1'b1   // an independent population count per position
   } pbx_rank_style_e;

   localparam int unsigned PBX_DEF_W        = 64;
   localparam int unsigned PBX_DEF_NARROW_W = 32;
endpackage

// File: rtl/pbx_width_gate.sv
// Clears mask bits above the narrow width when narrow operands are selected.
module pbx_width_gate #(
   parameter int unsigned W        = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic         wide,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] mask_o
);
   localparam bit HAS_NARROW = (NARROW_W < W);

   generate
      if (HAS_NARROW) begin : g_gate
         localparam int unsigned UPPER_W = W - NARROW_W;
         assign mask_o = wide ? mask_i
                              : {{UPPER_W{1'b0}}, mask_i[NARROW_W-1:0]};
      end else begin : g_pass
         logic unused_wide;
         assign unused_wide = wide;
         assign mask_o      = mask_i;
      end
   endgenerate
endmodule

// File: rtl/pbx_rank.sv
// For each position i: rank[i] = number of set mask bits strictly below i.
module pbx_rank
   import pbx_pkg::*;
#(
   parameter int unsigned     W     = 64,
   parameter pbx_rank_style_e STYLE = PBX_RANK_RIPPLE,
   localparam int unsigned    RW    = $clog2(W)
) (
   input  logic [W-1:0]         mask,
   output logic [W-1:0][RW-1:0] rank
);
   generate
      if (STYLE == PBX_RANK_RIPPLE) begin : g_ripple
         localparam int unsigned AW = RW + 1;
         always_comb begin
            logic [AW-1:0] acc;
            acc = '0;
            for (int i = 0; i < W; i++) begin
               rank[i] = acc[RW-1:0];
               acc     = acc + AW'(mask[i]);
            end
         end
      end else begin : g_lookahead
         for (genvar i = 0; i < W; i++) begin : g_pos
            logic [W-1:0] below;
            assign below   = mask & ((W'(1) << i) - W'(1));
            assign rank[i] = RW'($countones(below));
         end
      end
   endgenerate
endmodule

// File: rtl/pbx_select.sv
// Each result bit k takes the data bit whose mask bit is set and whose rank equals k.
module pbx_select #(
   parameter int unsigned  W  = 64,
   localparam int unsigned RW = $clog2(W)
) (
   input  logic [W-1:0]         data,
   input  logic [W-1:0]         mask,
   input  logic [W-1:0][RW-1:0] rank,
   output logic [W-1:0]         result
);
   generate
      for (genvar k = 0; k < W; k++) begin : g_dst
         // A source at position i has rank <= i, so only i >= k can land on k.
         always_comb begin
            logic hit;
            hit = 1'b0;
            for (int i = k; i < W; i++) begin
               hit = hit | (mask[i] & data[i] & (rank[i] == RW'(k)));
            end
            result[k] = hit;
         end
      end
   endgenerate
endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
   import pbx_pkg::*;
#(
   parameter int unsigned     W          = PBX_DEF_W,
   parameter int unsigned     NARROW_W   = PBX_DEF_NARROW_W,
   parameter pbx_rank_style_e RANK_STYLE = PBX_RANK_RIPPLE
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         in_wide,
   input  logic         in_bad_enc,
   input  logic [W-1:0] in_data,
   input  logic [W-1:0] in_mask,
   output logic         out_valid,
   output logic [W-1:0] out_result,
   output logic         out_fault
);
   localparam int unsigned RW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("pbx_unit: W must be at least 2");
      end
      if (NARROW_W < 1 || NARROW_W > W) begin : g_bad_narrow
         $error("pbx_unit: NARROW_W must lie in 1..W");
      end
   endgenerate

   logic                  take;
   logic                  trap;
   logic [W-1:0]          mask_g;
   logic [W-1:0][RW-1:0]  rank;
   logic [W-1:0]          packed_bits;

   assign take = in_valid & ~in_bad_enc;
   assign trap = in_valid &  in_bad_enc;

   pbx_width_gate #(.W(W), .NARROW_W(NARROW_W)) u_gate (
      .wide   (in_wide),
      .mask_i (in_mask),
      .mask_o (mask_g)
   );

   pbx_rank #(.W(W), .STYLE(RANK_STYLE)) u_rank (
      .mask (mask_g),
      .rank (rank)
   );

   pbx_select #(.W(W)) u_sel (
      .data   (in_data),
      .mask   (mask_g),
      .rank   (rank),
      .result (packed_bits)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_fault  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= take;
         out_fault <= trap;
         if (take) begin
            out_result <= packed_bits;
         end
      end
   end
endmodule

// File: rtl/pbx_unit_chk.sv
module pbx_unit_chk #(
   parameter int unsigned W        = 64,
   parameter int unsigned NARROW_W = 32
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         in_wide,
   input logic         in_bad_enc,
   input logic [W-1:0] in_data,
   input logic [W-1:0] in_mask,
   input logic         out_valid,
   input logic [W-1:0] out_result,
   input logic         out_fault
);
   logic unused_data;
   assign unused_data = ^in_data;

   assert_accept_latency_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_bad_enc) |=> out_valid);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_fault));

   assert_fault_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_bad_enc) |=> (out_fault && !out_valid));

   assert_fault_holds_result_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_bad_enc) |=> $stable(out_result));

   assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_fault));

   assert_upper_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_bad_enc) |=>
         ((out_result >> $countones($past(in_mask))) == '0));

   assert_zero_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_bad_enc && in_mask == '0) |=> (out_result == '0));

   generate
      if (NARROW_W < W) begin : g_narrow
         assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_bad_enc && !in_wide) |=>
               (out_result[W-1:NARROW_W] == '0));
      end else begin : g_no_narrow
         logic unused_wide;
         assign unused_wide = in_wide;
      end
   endgenerate

   assert_reset_clears_R8: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !out_fault && out_result == '0));
endmodule

bind pbx_unit pbx_unit_chk #(.W(W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_pbx_unit.sv
`timescale 1ns/1ps
module sim_pbx_unit;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid, in_wide, in_bad_enc;
   logic [W-1:0] in_data, in_mask;
   logic         out_valid, out_fault;
   logic [W-1:0] out_result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pbx_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
      .in_bad_enc(in_bad_enc), .in_data(in_data), .in_mask(in_mask),
      .out_valid(out_valid), .out_result(out_result), .out_fault(out_fault)
   );

   function automatic logic [W-1:0] model(logic [W-1:0] d, logic [W-1:0] m, bit wide);
      logic [W-1:0] r;
      int n, k;
      r = '0;
      k = 0;
      n = wide ? 64 : 32;
      for (int i = 0; i < n; i++) begin
         if (m[i]) begin
            r[k] = d[i];
            k++;
         end
      end
      return r;
   endfunction

   task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      in_valid = 1'b0; in_bad_enc = 1'b0; in_wide = 1'b1;
      in_data = '0; in_mask = '0;
   endtask

   // Drive one good operation; the result is sampled at the next falling edge.
   task automatic issue_and_check(string req, logic [W-1:0] d, logic [W-1:0] m, bit wide);
      in_valid = 1'b1; in_bad_enc = 1'b0; in_wide = wide;
      in_data = d; in_mask = m;
      @(negedge clk);
      chk({req, " valid"}, W'(out_valid), W'(1));
      chk({req, " result"}, out_result, model(d, m, wide));
   endtask

   task automatic t_reset();
      rst = 1'b1;
      idle();
      repeat (3) @(negedge clk);
      chk("R8 valid after reset", W'(out_valid), W'(0));
      chk("R8 fault after reset", W'(out_fault), W'(0));
      chk("R8 result after reset", out_result, '0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_worked_example();
      logic [W-1:0] d = 64'hA5A5_F0F0_9ABC_DEF1;
      logic [W-1:0] m = 64'h0;
      logic [W-1:0] e = '0;
      m[2] = 1'b1; m[5] = 1'b1; m[7] = 1'b1; m[28] = 1'b1;
      e[0] = d[2]; e[1] = d[5]; e[2] = d[7]; e[3] = d[28];
      in_valid = 1'b1; in_bad_enc = 1'b0; in_wide = 1'b0;
      in_data = d; in_mask = m;
      @(negedge clk);
      chk("R1 worked example", out_result, e);
      idle();
      @(negedge clk);
      chk("R6 idle drops valid", W'(out_valid), W'(0));
   endtask

   // Consecutive-cycle stream of random operands.
   task automatic t_random(bit wide, int n);
      for (int j = 0; j < n; j++) begin
         logic [W-1:0] d, m;
         d = {$urandom, $urandom};
         m = {$urandom, $urandom};
         if (j % 4 == 1) m = m & {$urandom, $urandom};
         issue_and_check(wide ? "R1 R6 random wide" : "R1 R6 random narrow", d, m, wide);
         chk("R2 upper zero", out_result >> $countones(wide ? m : (m & 64'hFFFF_FFFF)), '0);
      end
      idle();
      @(negedge clk);
   endtask

   task automatic t_zero_mask();
      issue_and_check("R4 zero mask wide", 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1);
      chk("R4 zero mask wide value", out_result, '0);
      issue_and_check("R4 zero mask narrow", 64'hDEAD_BEEF_CAFE_F00D, '0, 1'b0);
      chk("R4 zero mask narrow value", out_result, '0);
      idle();
      @(negedge clk);
   endtask

   task automatic t_full_mask();
      issue_and_check("R5 full mask wide", 64'h0123_4567_89AB_CDEF, '1, 1'b1);
      chk("R5 full mask wide identity", out_result, 64'h0123_4567_89AB_CDEF);
      issue_and_check("R5 full mask narrow", 64'h0123_4567_89AB_CDEF, '1, 1'b0);
      chk("R5 full mask narrow identity", out_result, 64'h0000_0000_89AB_CDEF);
      idle();
      @(negedge clk);
   endtask

   task automatic t_narrow_upper();
      // Upper mask and data bits set in narrow mode must not reach the result.
      issue_and_check("R3 narrow junk upper", 64'hFFFF_FFFF_0000_000F,
                      64'hFFFF_FFFF_0000_0003, 1'b0);
      chk("R3 narrow result", out_result, 64'h3);
      chk("R3 narrow upper half", {32'h0, out_result[63:32]}, '0);
      issue_and_check("R3 wide uses upper", 64'h8000_0000_0000_0000,
                      64'h8000_0000_0000_0000, 1'b1);
      chk("R3 wide upper bit", out_result, 64'h1);
      idle();
      @(negedge clk);
   endtask

   task automatic t_bad_enc();
      issue_and_check("R7 setup", 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00F0, 1'b1);
      chk("R7 setup value", out_result, 64'hF);
      in_valid = 1'b1; in_bad_enc = 1'b1; in_wide = 1'b1;
      in_data = '1; in_mask = '1;
      @(negedge clk);
      chk("R7 fault raised", W'(out_fault), W'(1));
      chk("R7 no valid on fault", W'(out_valid), W'(0));
      chk("R7 result held", out_result, 64'hF);
      issue_and_check("R7 after fault", 64'h5, 64'h5, 1'b1);
      chk("R7 fault cleared", W'(out_fault), W'(0));
      idle();
      @(negedge clk);
      chk("R6 idle no fault", W'(out_fault), W'(0));
   endtask

   initial begin
      t_reset();
      t_worked_example();
      t_random(1'b1, 300);
      t_random(1'b0, 300);
      t_zero_mask();
      t_full_mask();
      t_narrow_upper();
      t_bad_enc();
      t_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule